// File: doc/BRIEF.md
# Split-Read Seconds Counter with Snapshot

This block keeps time as a free-running 48-bit count of seconds. A tick input pulses at 32768 Hz. A prescaler divides it down, and the seconds count advances by one after every 32768 ticks. Software reaches the count through a simple synchronous 32-bit register port. The port has a byte address, a write strobe, write data, a read strobe and registered read data. Read data appears on the clock edge after the read strobe and holds until the next read.

The count is split over two words. The low word carries seconds bits 31:0. The high word carries bits 47:32 in its lower 16 bits. A two-bit mode field in a control word picks how the high word is read.

In snapshot mode, reading the low word takes a copy of the high bits. The next high-word read returns that copy and drops it. So a low-then-high read pair cannot tear when a carry ripples into the high bits between the two reads. In any other mode, each read returns the live bits.

Writing either word loads that part of the count. A write also restarts the prescaler, so the first increment after a load comes a full second later.

Top module: `split_seconds_counter`

## Requirements
- R1: After reset the count, the prescaler and the mode field are 0, and the read data output is 0.
- R2: The count rises by exactly one on the clock edge that samples the 32768th tick pulse since the prescaler was last at 0. Cycles with the tick input low do not advance the prescaler.
- R3: A read of address 0x08 returns count bits 31:0. A read of address 0x0C returns count bits 47:32 in data bits 15:0, with data bits 31:16 reading 0.
- R4: A write to 0x08 loads count bits 31:0 from write data 31:0. A write to 0x0C loads count bits 47:32 from write data 15:0, and write data bits 31:16 are ignored.
- R5: A write to 0x08 or 0x0C sets the prescaler to 0. After such a write, 32767 tick pulses leave the count unchanged, and the next pulse increments it. A load takes priority over an increment in the same cycle.
- R6: When the mode field equals 2, a read of 0x08 captures count bits 47:32. The next read of 0x0C returns the captured value even if a carry has since changed the live bits.
- R7: A read of 0x0C releases the captured value. A later high-word read with no low-word read in between returns the live bits.
- R8: When the mode field is not 2, reads of 0x0C return the live bits 47:32 and no value is captured.
- R9: The mode field is bits 25:24 of the control word at 0x50. Reading 0x50 returns the field in those bits, with every other bit 0. A write to 0x50 also discards any captured value.
- R10: Reads of any other address return 0, and writes to any other address change neither the count nor the mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per 32768 Hz reference period |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_rd |

## Verification
The hardest case to reach is a carry into the high bits landing between the low-word read and the high-word read. Only that case separates a snapshot from a live read. The stimulus loads a low word of all ones and restarts the prescaler. It then issues exactly 32767 tick pulses, reads the low word, issues one more pulse and reads the high word. The same sequence runs in snapshot mode and in live mode, and the two modes must return different high words.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  localparam int BUS_W  = 32;
  localparam int FM_LSB = 24;

  typedef enum logic [1:0] {
    FM_LIVE    = 2'd0,
    FM_RSVD_A  = 2'd1,
    FM_LOWREAD = 2'd2,
    FM_RSVD_B  = 2'd3
  } fmode_t;

  // Place the mode field into a control word; all other bits stay zero.
  function automatic logic [BUS_W-1:0] ctrl_word(input logic [1:0] fm);
    logic [BUS_W-1:0] w;
    w = '0;
    w[FM_LSB +: 2] = fm;
    return w;
  endfunction

  // Prescaler wrap condition: the sampled tick is the last of the second.
  function automatic logic at_last_tick(input int unsigned pre, input int unsigned div);
    return pre == (div - 1);
  endfunction

endpackage

// File: rtl/ssc_prescaler.sv
module ssc_prescaler #(
  parameter int TICKS_PER_SEC = 32768,
  localparam int PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  output logic [PRE_W-1:0] pre_q,
  output logic             wrap
);
  import ssc_pkg::*;

  logic top;
  assign top  = at_last_tick(int'(pre_q), TICKS_PER_SEC);
  assign wrap = tick && top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clear) begin
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= top ? '0 : pre_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/ssc_seconds.sv
module ssc_seconds #(
  parameter int CNT_W = 48,
  localparam int LO_W = 32,
  localparam int HI_W = CNT_W - LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [LO_W-1:0]  wdata,
  output logic [CNT_W-1:0] cnt_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld_lo || ld_hi) begin
      if (ld_lo) cnt_q[LO_W-1:0]     <= wdata;
      if (ld_hi) cnt_q[CNT_W-1:LO_W] <= wdata[HI_W-1:0];
    end else if (inc) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ssc_bus.sv
module ssc_bus #(
  parameter int CNT_W    = 48,
  parameter int ADDR_W   = 8,
  parameter int LO_OFS   = 'h08,
  parameter int HI_OFS   = 'h0C,
  parameter int CTRL_OFS = 'h50,
  localparam int LO_W = 32,
  localparam int HI_W = CNT_W - LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  input  logic [CNT_W-1:0]  cnt_q,
  output logic              ld_lo,
  output logic              ld_hi,
  output logic [1:0]        fmode,
  output logic              hold_valid,
  output logic [31:0]       bus_rdata
);
  import ssc_pkg::*;

  logic            sel_lo, sel_hi, sel_ctrl;
  logic [HI_W-1:0] hold_q;
  logic [HI_W-1:0] hi_view;
  logic [31:0]     rd_mux;
  logic            unused_wbits;

  assign sel_lo   = bus_addr == LO_OFS[ADDR_W-1:0];
  assign sel_hi   = bus_addr == HI_OFS[ADDR_W-1:0];
  assign sel_ctrl = bus_addr == CTRL_OFS[ADDR_W-1:0];

  assign ld_lo = bus_wr && sel_lo;
  assign ld_hi = bus_wr && sel_hi;

  assign unused_wbits = ^{bus_wdata[31:FM_LSB+2], bus_wdata[FM_LSB-1:0]};

  assign hi_view = hold_valid ? hold_q : cnt_q[CNT_W-1:LO_W];

  always_comb begin
    rd_mux = '0;
    if (sel_lo)        rd_mux = cnt_q[LO_W-1:0];
    else if (sel_hi)   rd_mux = {{(32-HI_W){1'b0}}, hi_view};
    else if (sel_ctrl) rd_mux = ctrl_word(fmode);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmode      <= FM_LIVE;
      hold_q     <= '0;
      hold_valid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      if (bus_wr && sel_ctrl) fmode <= bus_wdata[FM_LSB +: 2];
      if (bus_rd) bus_rdata <= rd_mux;
      if (bus_wr && sel_ctrl) begin
        hold_valid <= 1'b0;
      end else if (bus_rd && sel_lo && fmode == FM_LOWREAD) begin
        hold_valid <= 1'b1;
        hold_q     <= cnt_q[CNT_W-1:LO_W];
      end else if (bus_rd && sel_hi) begin
        hold_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/split_seconds_counter.sv
module split_seconds_counter #(
  parameter int CNT_W         = 48,
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 8,
  parameter int LO_OFS        = 'h08,
  parameter int HI_OFS        = 'h0C,
  parameter int CTRL_OFS      = 'h50,
  localparam int PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata
);

  // Named internal events, visible to the bound checker.
  logic             sec_wrap;
  logic             ld_lo, ld_hi, any_ld;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       fmode;
  logic             hold_valid;

  assign any_ld = ld_lo || ld_hi;

  ssc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .clear (any_ld),
    .pre_q (pre_q),
    .wrap  (sec_wrap)
  );

  ssc_seconds #(.CNT_W(CNT_W)) u_sec (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (sec_wrap),
    .ld_lo (ld_lo),
    .ld_hi (ld_hi),
    .wdata (bus_wdata),
    .cnt_q (cnt_q)
  );

  ssc_bus #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .LO_OFS(LO_OFS), .HI_OFS(HI_OFS), .CTRL_OFS(CTRL_OFS)
  ) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .cnt_q      (cnt_q),
    .ld_lo      (ld_lo),
    .ld_hi      (ld_hi),
    .fmode      (fmode),
    .hold_valid (hold_valid),
    .bus_rdata  (bus_rdata)
  );

endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
  parameter int CNT_W  = 48,
  parameter int ADDR_W = 8,
  parameter int PRE_W  = 15,
  parameter int HI_OFS = 'h0C,
  parameter int LO_OFS = 'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              sec_wrap,
  input logic              any_ld,
  input logic [PRE_W-1:0]  pre_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [1:0]        fmode,
  input logic              hold_valid
);

  assert_hi_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == HI_OFS[ADDR_W-1:0]) |=> bus_rdata[31:16] == 16'h0);

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wrap && !any_ld) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  assert_hold_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_wrap && !any_ld) |=> $stable(cnt_q));

  assert_pre_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_ld |=> pre_q == '0);

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == LO_OFS[ADDR_W-1:0] && fmode == 2'd2) |=> hold_valid);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == HI_OFS[ADDR_W-1:0]) |=> !hold_valid);

  assert_latch_only_snapshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |-> fmode == 2'd2);

endmodule

bind split_seconds_counter ssc_checker #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W), .HI_OFS(HI_OFS), .LO_OFS(LO_OFS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .sec_wrap   (sec_wrap),
  .any_ld     (any_ld),
  .pre_q      (pre_q),
  .cnt_q      (cnt_q),
  .fmode      (fmode),
  .hold_valid (hold_valid)
);

// File: tb/sim_split_seconds_counter.sv
`timescale 1ns/1ps
module sim_split_seconds_counter;

  localparam logic [7:0] A_LO   = 8'h08;
  localparam logic [7:0] A_HI   = 8'h0C;
  localparam logic [7:0] A_CTRL = 8'h50;
  localparam int SEC = 32768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int fails  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  always #2.5 clk = ~clk;

  split_seconds_counter u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data one cycle after each read strobe.
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata, e);
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_expect(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    read_expect(A_LO,   32'h0, "R1 low word after reset");
    read_expect(A_HI,   32'h0, "R1 high word after reset");
    read_expect(A_CTRL, 32'h0, "R1 control after reset");

    // R4 load, R3 layout
    bus_write(A_LO, 32'h89AB_CDEF);
    bus_write(A_HI, 32'hABCD_1234);
    read_expect(A_LO, 32'h89AB_CDEF, "R4 low load");
    read_expect(A_HI, 32'h0000_1234, "R3 R4 high layout, upper write bits ignored");

    // R2: gapped tick pulses, one short of a second, then the last one
    run_ticks(SEC/2);
    repeat (3) @(negedge clk);
    run_ticks(SEC/2 - 1);
    read_expect(A_LO, 32'h89AB_CDEF, "R2 no step before 32768th tick");
    run_ticks(1);
    read_expect(A_LO, 32'h89AB_CDF0, "R2 step on 32768th tick");

    // R5: write restarts the prescaler
    run_ticks(100);
    bus_write(A_LO, 32'h0000_0010);
    run_ticks(SEC - 1);
    read_expect(A_LO, 32'h0000_0010, "R5 no step 32767 ticks after write");
    run_ticks(1);
    read_expect(A_LO, 32'h0000_0011, "R5 step one full second after write");

    // R9: control field
    bus_write(A_CTRL, 32'hFFFF_FFFF);
    read_expect(A_CTRL, 32'h0300_0000, "R9 only bits 25:24 kept");
    bus_write(A_CTRL, 32'h0200_0000);
    read_expect(A_CTRL, 32'h0200_0000, "R9 snapshot mode set");

    // R6/R7: carry between the two reads in snapshot mode
    bus_write(A_LO, 32'hFFFF_FFFF);
    bus_write(A_HI, 32'h0000_1234);
    run_ticks(SEC - 1);
    read_expect(A_LO, 32'hFFFF_FFFF, "R6 low read before carry");
    run_ticks(1);
    read_expect(A_HI, 32'h0000_1234, "R6 frozen high after carry");
    read_expect(A_HI, 32'h0000_1235, "R7 live high after release");
    read_expect(A_LO, 32'h0000_0000, "R7 low after carry");

    // R8: same sequence in live mode tears
    bus_write(A_CTRL, 32'h0);
    bus_write(A_LO, 32'hFFFF_FFFF);
    bus_write(A_HI, 32'h0000_1234);
    run_ticks(SEC - 1);
    read_expect(A_LO, 32'hFFFF_FFFF, "R8 low read before carry");
    run_ticks(1);
    read_expect(A_HI, 32'h0000_1235, "R8 live high, no capture");

    // R10: other addresses
    read_expect(8'h40, 32'h0, "R10 unmapped read");
    bus_write(8'h44, 32'hDEAD_BEEF);
    bus_write(8'h10, 32'h0300_0000);
    read_expect(A_LO,   32'h0000_0000, "R10 low unchanged by stray write");
    read_expect(A_HI,   32'h0000_1235, "R10 high unchanged by stray write");
    read_expect(A_CTRL, 32'h0000_0000, "R10 mode unchanged by stray write");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule